// File: doc/BRIEF.md
# SPI Serial EEPROM Command Interface

This block is the serial slave front end of a 1024-byte nonvolatile store. It oversamples the serial clock, select and data lines with the system clock. Bits are taken on rising serial-clock edges and returned after falling edges. Each select-low frame starts with an 8-bit opcode, sent most significant bit first. Depending on the opcode, the frame then carries a 16-bit address, write data, a lock code, or nothing. Reads stream bytes out of a synchronous storage array and increment the address after each byte. Writes fill a 16-byte page buffer, which is copied into the array by a self-timed write cycle.

Writes require a write-enable latch. The latch is only set when a dedicated one-byte frame ends cleanly. A page write or a lock update starts only when select rises exactly on a byte boundary. A 3-bit lock code marks a region of the array as read-only. While a write cycle runs, the status opcode is the only one that is served, and it reports busy by holding the output high.

Top module: `spi_eeprom_if`

## Requirements
- R1: After reset, no frame is served until select has been seen going from high to low; clocks sent while select was held low from reset produce no output enable.
- R2: The output enable is low whenever select is high, and it is low after reset.
- R3: Opcode 0x03 followed by a 16-bit address streams stored bytes one after another, incrementing the address after each byte and wrapping from 0x3FF to 0x000.
- R4: Address bits 15:10 are ignored by both reads and writes.
- R5: Opcode 0x02 with address and data changes nothing unless the write-enable latch is set.
- R6: Opcode 0x06 sets the latch only if select rises right after its eighth bit; any further clock in that frame cancels it.
- R7: Write data fills one 16-byte page; address bits 9:4 stay fixed, and the in-page index wraps so that later bytes overwrite earlier ones.
- R8: A write cycle starts only when select rises after bit 0 of a data byte; select rising in the middle of a byte abandons the frame.
- R9: Opcode 0x05 returns all ones while a write cycle runs; otherwise it returns bits 7:3 as zero and bits 2:0 as the lock code, repeated for as long as clocks continue.
- R10: While a write cycle runs, any opcode other than 0x05 is ignored and the output enable stays low.
- R11: Opcode 0x01 followed by lock bytes stores bits 2:0 of the last complete byte when select rises on a byte boundary with the latch set; a partial byte leaves the code unchanged.
- R12: A write to a page inside the locked region starts no cycle and leaves the array unchanged. The regions by code are: 0 none, 1 0x000-0x0FF, 2 0x100-0x1FF, 3 0x200-0x2FF, 4 0x300-0x3FF, 5 0x000-0x1FF, 6 0x000-0x00F, 7 0x3F0-0x3FF.
- R13: The latch is cleared when a write or lock cycle starts, and by opcode 0x04.
- R14: An unknown opcode makes the block ignore the rest of the frame, with the output enable kept low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Active-low select |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o (high-impedance when low) |

## Verification
Some rules are checked on every cycle: the output stays high and only the status frame drives it while a write cycle runs, ignored frames never enable the output, the latch is clear when a cycle starts, a commit is only issued with select high, and the lock code moves only on a lock commit. Other behaviour can only be shown by the bench's scenarios. These are data coming back at the right addresses, address wrap in the array and in the page, and upper address bits being ignored. They also cover frames that are dropped: those cut mid-byte, those sent without the latch, those to locked pages, and those with an extra clock after the enable opcode.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_OP, S_WEN, S_AHI, S_ALO, S_RD, S_WR, S_LOCK, S_STAT, S_IGN
  } eep_state_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_LOCK  = 8'h01;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;

  localparam int LOCK_W = 3;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_rise_o,
  output logic cs_fall_o,
  output logic cs_o,
  output logic si_o
);
  logic [STAGES-1:0] sck_p, cs_p, si_p;
  logic sck_d, cs_d;

  // select resets low so a line held low from reset yields no falling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_p <= '0;
      cs_p  <= '0;
      si_p  <= '0;
      sck_d <= 1'b0;
      cs_d  <= 1'b0;
    end else begin
      sck_p <= {sck_p[STAGES-2:0], sck_i};
      cs_p  <= {cs_p[STAGES-2:0], cs_ni};
      si_p  <= {si_p[STAGES-2:0], si_i};
      sck_d <= sck_p[STAGES-1];
      cs_d  <= cs_p[STAGES-1];
    end
  end

  assign sck_rise_o = sck_p[STAGES-1] & ~sck_d;
  assign sck_fall_o = ~sck_p[STAGES-1] & sck_d;
  assign cs_rise_o  = cs_p[STAGES-1] & ~cs_d;
  assign cs_fall_o  = ~cs_p[STAGES-1] & cs_d;
  assign cs_o       = cs_p[STAGES-1];
  assign si_o       = si_p[STAGES-1];
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int AW  = 10,
  parameter int PW  = 4,
  parameter int PGW = AW - PW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_rise_i,
  input  logic                sck_fall_i,
  input  logic                cs_rise_i,
  input  logic                cs_fall_i,
  input  logic                cs_ni,
  input  logic                si_i,
  input  logic                busy_i,
  input  logic [LOCK_W-1:0]   lock_i,
  input  logic [7:0]          rd_data_i,
  input  logic                page_locked_i,
  output logic [AW-1:0]       rd_addr_o,
  output logic                buf_we_o,
  output logic [PW-1:0]       buf_idx_o,
  output logic [7:0]          buf_data_o,
  output logic                buf_clr_o,
  output logic                commit_o,
  output logic [PGW-1:0]      commit_page_o,
  output logic                lock_we_o,
  output logic [LOCK_W-1:0]   lock_data_o,
  output logic [PGW-1:0]      query_page_o,
  output logic                wel_o,
  output eep_state_e          st_o,
  output logic                so_o,
  output logic                so_oe_o
);
  localparam int HW = AW - 8;

  eep_state_e        st_q;
  logic [2:0]        bcnt_q, tx_cnt_q;
  logic [6:0]        shreg_q;
  logic [HW-1:0]     ahi_q;
  logic [AW-1:0]     addr_q;
  logic              is_rd_q, any_q, wel_q, lock_have_q;
  logic [LOCK_W-1:0] lock_pend_q;
  logic [7:0]        tx_q;
  logic              so_q, oe_q;
  logic              rd_req_q, rd_pend_q;
  logic              buf_we_q, buf_clr_q, commit_q, lock_we_q;
  logic [PW-1:0]     buf_idx_q;
  logic [7:0]        buf_data_q;

  logic [7:0] byte_in, status_byte;
  logic       byte_done;

  assign byte_in     = {shreg_q, si_i};
  assign byte_done   = sck_rise_i && (bcnt_q == 3'd7);
  assign status_byte = {{(8-LOCK_W){1'b0}}, lock_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      bcnt_q      <= '0;
      tx_cnt_q    <= '0;
      shreg_q     <= '0;
      ahi_q       <= '0;
      addr_q      <= '0;
      is_rd_q     <= 1'b0;
      any_q       <= 1'b0;
      wel_q       <= 1'b0;
      lock_have_q <= 1'b0;
      lock_pend_q <= '0;
      tx_q        <= '0;
      so_q        <= 1'b0;
      oe_q        <= 1'b0;
      rd_req_q    <= 1'b0;
      rd_pend_q   <= 1'b0;
      buf_we_q    <= 1'b0;
      buf_clr_q   <= 1'b0;
      buf_idx_q   <= '0;
      buf_data_q  <= '0;
      commit_q    <= 1'b0;
      lock_we_q   <= 1'b0;
    end else begin
      rd_req_q  <= 1'b0;
      rd_pend_q <= rd_req_q;
      buf_we_q  <= 1'b0;
      buf_clr_q <= 1'b0;
      commit_q  <= 1'b0;
      lock_we_q <= 1'b0;
      if (rd_pend_q) tx_q <= rd_data_i;

      if (cs_fall_i) begin
        st_q        <= S_OP;
        bcnt_q      <= '0;
        oe_q        <= 1'b0;
        any_q       <= 1'b0;
        lock_have_q <= 1'b0;
      end else if (cs_rise_i) begin
        st_q <= S_IDLE;
        oe_q <= 1'b0;
        if (st_q == S_WEN) wel_q <= 1'b1;
        if (st_q == S_WR && bcnt_q == 3'd0 && any_q && wel_q && !busy_i && !page_locked_i) begin
          commit_q <= 1'b1;
          wel_q    <= 1'b0;
        end
        if (st_q == S_LOCK && bcnt_q == 3'd0 && lock_have_q && wel_q && !busy_i) begin
          lock_we_q <= 1'b1;
          wel_q     <= 1'b0;
        end
      end else if (st_q != S_IDLE) begin
        if (sck_rise_i) begin
          shreg_q <= byte_in[6:0];
          bcnt_q  <= bcnt_q + 3'd1;
        end
        // any clock after the enable opcode cancels it
        if (sck_rise_i && st_q == S_WEN) st_q <= S_IGN;
        else if (byte_done) begin
          case (st_q)
            S_OP: begin
              if (busy_i && byte_in != OP_RDSR) st_q <= S_IGN;
              else begin
                case (byte_in)
                  OP_WREN: st_q <= S_WEN;
                  OP_WRDI: begin wel_q <= 1'b0; st_q <= S_IGN; end
                  OP_LOCK: st_q <= S_LOCK;
                  OP_RDSR: begin
                    st_q     <= S_STAT;
                    tx_q     <= status_byte;
                    tx_cnt_q <= '0;
                    oe_q     <= 1'b1;
                    if (busy_i) so_q <= 1'b1;
                  end
                  OP_WRITE: begin st_q <= S_AHI; is_rd_q <= 1'b0; buf_clr_q <= 1'b1; end
                  OP_READ:  begin st_q <= S_AHI; is_rd_q <= 1'b1; end
                  default:  st_q <= S_IGN;
                endcase
              end
            end
            S_AHI: begin
              ahi_q <= byte_in[HW-1:0];
              st_q  <= S_ALO;
            end
            S_ALO: begin
              addr_q <= {ahi_q, byte_in};
              if (is_rd_q) begin
                st_q     <= S_RD;
                rd_req_q <= 1'b1;
                oe_q     <= 1'b1;
                tx_cnt_q <= '0;
              end else st_q <= S_WR;
            end
            S_WR: begin
              buf_we_q   <= 1'b1;
              buf_idx_q  <= addr_q[PW-1:0];
              buf_data_q <= byte_in;
              addr_q     <= {addr_q[AW-1:PW], addr_q[PW-1:0] + 1'b1};
              any_q      <= 1'b1;
            end
            S_LOCK: begin
              lock_pend_q <= byte_in[LOCK_W-1:0];
              lock_have_q <= 1'b1;
            end
            default: ;
          endcase
        end

        if (sck_fall_i && (st_q == S_RD || st_q == S_STAT)) begin
          so_q     <= (st_q == S_STAT && busy_i) ? 1'b1 : tx_q[3'd7 - tx_cnt_q];
          tx_cnt_q <= tx_cnt_q + 3'd1;
          if (tx_cnt_q == 3'd7) begin
            if (st_q == S_RD) begin
              addr_q   <= addr_q + 1'b1;
              rd_req_q <= 1'b1;
            end else tx_q <= status_byte;
          end
        end
      end
    end
  end

  assign rd_addr_o     = addr_q;
  assign buf_we_o      = buf_we_q;
  assign buf_idx_o     = buf_idx_q;
  assign buf_data_o    = buf_data_q;
  assign buf_clr_o     = buf_clr_q;
  assign commit_o      = commit_q;
  assign commit_page_o = addr_q[AW-1:PW];
  assign query_page_o  = addr_q[AW-1:PW];
  assign lock_we_o     = lock_we_q;
  assign lock_data_o   = lock_pend_q;
  assign wel_o         = wel_q;
  assign st_o          = st_q;
  assign so_o          = so_q;
  assign so_oe_o       = oe_q & ~cs_ni;
endmodule

// File: rtl/eep_store.sv
module eep_store
  import eep_pkg::*;
#(
  parameter int AW           = 10,
  parameter int PW           = 4,
  parameter int WRITE_CYCLES = 1000,
  parameter int PGW          = AW - PW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic              buf_we_i,
  input  logic [PW-1:0]     buf_idx_i,
  input  logic [7:0]        buf_data_i,
  input  logic              buf_clr_i,
  input  logic              commit_i,
  input  logic [PGW-1:0]    commit_page_i,
  input  logic              lock_we_i,
  input  logic [LOCK_W-1:0] lock_data_i,
  input  logic [PGW-1:0]    query_page_i,
  output logic              page_locked_o,
  output logic [LOCK_W-1:0] lock_o,
  output logic              busy_o
);
  localparam int PAGES = 1 << PW;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(WRITE_CYCLES + PAGES + 1);
  localparam logic [CW-1:0] PAGES_C = CW'(PAGES);
  localparam logic [CW-1:0] LAST_C  = CW'(WRITE_CYCLES - 1);

  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGES];
  logic [PAGES-1:0]  pvalid_q;
  logic              busy_q;
  logic [CW-1:0]     wcnt_q;
  logic [PGW-1:0]    page_q;
  logic [LOCK_W-1:0] lock_q;
  logic              wr_en;
  logic [PW-1:0]     widx;

  assign widx  = wcnt_q[PW-1:0];
  assign wr_en = busy_q && (wcnt_q < PAGES_C) && pvalid_q[widx];

  always_ff @(posedge clk_i) begin
    rd_data_o <= mem[rd_addr_i];
    if (wr_en) mem[{page_q, widx}] <= pbuf[widx];
  end

  always_ff @(posedge clk_i) begin
    if (buf_we_i) pbuf[buf_idx_i] <= buf_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pvalid_q <= '0;
      busy_q   <= 1'b0;
      wcnt_q   <= '0;
      page_q   <= '0;
      lock_q   <= '0;
    end else begin
      if (buf_clr_i) pvalid_q <= '0;
      else if (buf_we_i) pvalid_q[buf_idx_i] <= 1'b1;
      if (commit_i) begin
        busy_q <= 1'b1;
        wcnt_q <= '0;
        page_q <= commit_page_i;
      end else if (lock_we_i) begin
        busy_q <= 1'b1;
        wcnt_q <= PAGES_C;
        lock_q <= lock_data_i;
      end else if (busy_q) begin
        wcnt_q <= wcnt_q + 1'b1;
        if (wcnt_q >= LAST_C) busy_q <= 1'b0;
      end
    end
  end

  // protected region decode, aligned to whole pages
  logic [1:0]        quarter;
  logic [LOCK_W-1:0] qsel;
  assign quarter = query_page_i[PGW-1 -: 2];
  assign qsel    = lock_q - 3'd1;

  always_comb begin
    case (lock_q)
      3'd0:                      page_locked_o = 1'b0;
      3'd1, 3'd2, 3'd3, 3'd4:    page_locked_o = (quarter == qsel[1:0]);
      3'd5:                      page_locked_o = ~query_page_i[PGW-1];
      3'd6:                      page_locked_o = (query_page_i == '0);
      default:                   page_locked_o = &query_page_i;
    endcase
  end

  assign lock_o = lock_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/spi_eeprom_if.sv
module spi_eeprom_if
  import eep_pkg::*;
#(
  parameter int AW           = 10,
  parameter int PW           = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  output logic so_o,
  output logic so_oe_o
);
  localparam int PGW = AW - PW;

  logic sck_rise, sck_fall, cs_rise, cs_fall, cs_s_w, si_s;
  logic [AW-1:0]     rd_addr;
  logic [7:0]        rd_data;
  logic              buf_we, buf_clr, commit_w, lock_we_w, page_locked, busy_w, wel_w;
  logic [PW-1:0]     buf_idx;
  logic [7:0]        buf_data;
  logic [PGW-1:0]    commit_page, query_page;
  logic [LOCK_W-1:0] lock_data, lock_w;
  eep_state_e        st_w;

  eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .si_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .cs_rise_o(cs_rise), .cs_fall_o(cs_fall),
    .cs_o(cs_s_w), .si_o(si_s)
  );

  eep_ctrl #(.AW(AW), .PW(PW)) u_ctrl (
    .clk_i, .rst_ni,
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
    .cs_rise_i(cs_rise), .cs_fall_i(cs_fall),
    .cs_ni, .si_i(si_s),
    .busy_i(busy_w), .lock_i(lock_w), .rd_data_i(rd_data),
    .page_locked_i(page_locked),
    .rd_addr_o(rd_addr),
    .buf_we_o(buf_we), .buf_idx_o(buf_idx), .buf_data_o(buf_data), .buf_clr_o(buf_clr),
    .commit_o(commit_w), .commit_page_o(commit_page),
    .lock_we_o(lock_we_w), .lock_data_o(lock_data),
    .query_page_o(query_page), .wel_o(wel_w), .st_o(st_w),
    .so_o, .so_oe_o
  );

  eep_store #(.AW(AW), .PW(PW), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
    .clk_i, .rst_ni,
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .buf_we_i(buf_we), .buf_idx_i(buf_idx), .buf_data_i(buf_data), .buf_clr_i(buf_clr),
    .commit_i(commit_w), .commit_page_i(commit_page),
    .lock_we_i(lock_we_w), .lock_data_i(lock_data),
    .query_page_i(query_page), .page_locked_o(page_locked),
    .lock_o(lock_w), .busy_o(busy_w)
  );
endmodule

// File: rtl/eep_chk.sv
module eep_chk
  import eep_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              so_o,
  input logic              so_oe_o,
  input logic              busy_w,
  input logic              wel_w,
  input logic              commit_w,
  input logic              lock_we_w,
  input logic [LOCK_W-1:0] lock_w,
  input logic              cs_s_w,
  input eep_state_e        st_w
);
  // R9
  busy_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_w && so_oe_o) |-> so_o);

  // R10
  busy_only_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_w && so_oe_o) |-> (st_w == S_STAT));

  // R13
  wel_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_w) |-> !wel_w);

  // R8
  commit_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_w || lock_we_w) |-> cs_s_w);

  // R11
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_we_w |=> $stable(lock_w));

  // R14
  ignore_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_w == S_IGN) |-> !so_oe_o);
endmodule

bind spi_eeprom_if eep_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .so_o(so_o), .so_oe_o(so_oe_o),
  .busy_w(busy_w), .wel_w(wel_w), .commit_w(commit_w), .lock_we_w(lock_we_w),
  .lock_w(lock_w), .cs_s_w(cs_s_w), .st_w(st_w)
);

// File: tb/spi_eeprom_if_test.sv
module spi_eeprom_if_test;
  localparam int WC = 1000;
  localparam int HP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b0, si = 1'b0;
  logic so, so_oe;
  int   n_tests = 0, n_fail = 0;
  bit   done = 1'b0, mon_en = 1'b0;

  logic [7:0] exp_v[$];
  string      exp_tag[$];
  logic [7:0] wbuf [32];
  logic [7:0] acc = '0;
  int         nb = 0;

  always #5 clk = ~clk;

  spi_eeprom_if #(.WRITE_CYCLES(WC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .so_o(so), .so_oe_o(so_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_v.push_back(v);
    exp_tag.push_back(tag);
  endtask

  // scoreboard monitor: assembles output bytes and compares with queued items
  always @(posedge sck) begin
    if (mon_en) begin
      acc = {acc[6:0], so_oe ? so : 1'bx};
      nb++;
      if (nb == 8) begin
        nb = 0;
        if (exp_v.size() == 0) chk(1'b0, "unexpected byte", {8'h0, acc}, 16'h0);
        else begin
          logic [7:0] v;
          string t;
          v = exp_v.pop_front();
          t = exp_tag.pop_front();
          chk(acc === v, t, {8'h0, acc}, {8'h0, v});
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_pulse();
    tick(HP); sck = 1'b1;
    tick(HP); sck = 1'b0;
  endtask

  task automatic xfer_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      si = b[i];
      sck_pulse();
    end
  endtask

  task automatic xfer(input logic [7:0] b);
    xfer_bits(b, 8);
  endtask

  task automatic fr_start();
    tick(1); cs_n = 1'b0; tick(HP);
  endtask

  task automatic fr_end();
    tick(HP); cs_n = 1'b1; tick(4 * HP);
  endtask

  task automatic op_only(input logic [7:0] op);
    fr_start(); xfer(op); fr_end();
  endtask

  task automatic write_frame(input logic [15:0] a, input int n);
    fr_start();
    xfer(8'h02); xfer(a[15:8]); xfer(a[7:0]);
    for (int i = 0; i < n; i++) xfer(wbuf[i]);
    fr_end();
  endtask

  task automatic read_frame(input logic [15:0] a, input int n);
    fr_start();
    xfer(8'h03); xfer(a[15:8]); xfer(a[7:0]);
    si = 1'b0; mon_en = 1'b1;
    repeat (n * 8) sck_pulse();
    mon_en = 1'b0;
    fr_end();
  endtask

  task automatic status_frame(input int n);
    fr_start();
    xfer(8'h05);
    si = 1'b0; mon_en = 1'b1;
    repeat (n * 8) sck_pulse();
    mon_en = 1'b0;
    fr_end();
  endtask

  task automatic lock_frame(input logic [7:0] code);
    fr_start(); xfer(8'h01); xfer(code); fr_end();
  endtask

  task automatic wait_wc();
    tick(WC + 100);
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(2);
    chk(!so_oe, "R2 reset oe", {15'h0, so_oe}, 16'h0);

    // R1: select low since reset, no frame served
    xfer(8'h05);
    for (int i = 0; i < 8; i++) begin
      sck_pulse();
      chk(!so_oe, "R1 no frame before select fall", {15'h0, so_oe}, 16'h0);
    end
    cs_n = 1'b1; tick(4 * HP);
    chk(!so_oe, "R2 deselected oe", {15'h0, so_oe}, 16'h0);

    // R9 busy status, R10 read ignored during cycle
    op_only(8'h06);
    wbuf[0] = 8'hC0; wbuf[1] = 8'hC1;
    write_frame(16'h0000, 2);
    expect_byte(8'hFF, "R9 busy status");
    status_frame(1);
    fr_start();
    xfer(8'h03); xfer(8'h00); xfer(8'h10);
    for (int i = 0; i < 8; i++) begin
      sck_pulse();
      chk(!so_oe, "R10 read ignored while busy", {15'h0, so_oe}, 16'h0);
    end
    fr_end();
    wait_wc();

    // R3 basic sequential read
    expect_byte(8'hC0, "R3 read addr0");
    expect_byte(8'hC1, "R3 read addr1");
    read_frame(16'h0000, 2);

    // R5 write needs the latch
    op_only(8'h06);
    wbuf[0] = 8'h11; write_frame(16'h0010, 1); wait_wc();
    wbuf[0] = 8'h22; write_frame(16'h0010, 1);
    expect_byte(8'h00, "R5 no cycle without latch");
    status_frame(1);
    expect_byte(8'h11, "R5 data kept");
    read_frame(16'h0010, 1);

    // R6 extra clock after enable opcode cancels it
    fr_start(); xfer(8'h06); xfer(8'h00); fr_end();
    wbuf[0] = 8'h33; write_frame(16'h0010, 1);
    expect_byte(8'h00, "R6 enable cancelled");
    status_frame(1);
    expect_byte(8'h11, "R6 data kept");
    read_frame(16'h0010, 1);

    // R4 upper address bits ignored
    op_only(8'h06);
    wbuf[0] = 8'h44; write_frame(16'hFC10, 1); wait_wc();
    expect_byte(8'h44, "R4 upper bits ignored");
    read_frame(16'hA810, 1);

    // R7 page wrap and R3 array wrap
    op_only(8'h06);
    for (int k = 0; k < 18; k++) wbuf[k] = 8'h50 + 8'(k);
    write_frame(16'h03FE, 18); wait_wc();
    expect_byte(8'h5E, "R7 in-page wrap 3FC");
    expect_byte(8'h5F, "R7 in-page wrap 3FD");
    expect_byte(8'h60, "R7 overwrite 3FE");
    expect_byte(8'h61, "R7 overwrite 3FF");
    expect_byte(8'hC0, "R3 wrap to 000");
    expect_byte(8'hC1, "R3 wrap to 001");
    read_frame(16'h03FC, 6);
    expect_byte(8'h52, "R7 page start");
    read_frame(16'h03F0, 1);

    // R8 mid-byte select rise abandons the write
    op_only(8'h06);
    wbuf[0] = 8'h66; write_frame(16'h0020, 1); wait_wc();
    op_only(8'h06);
    fr_start(); xfer(8'h02); xfer(8'h00); xfer(8'h20); xfer(8'h77); xfer_bits(8'hA0, 3); fr_end();
    expect_byte(8'h00, "R8 no cycle after partial byte");
    status_frame(1);
    expect_byte(8'h66, "R8 data kept");
    read_frame(16'h0020, 1);

    // R13 disable opcode clears the latch
    op_only(8'h06);
    op_only(8'h04);
    wbuf[0] = 8'h99; write_frame(16'h0020, 1);
    expect_byte(8'h00, "R13 no cycle after disable");
    status_frame(1);
    expect_byte(8'h66, "R13 data kept");
    read_frame(16'h0020, 1);

    // R11 last lock byte wins; R12 locked page
    op_only(8'h06);
    fr_start(); xfer(8'h01); xfer(8'h03); xfer(8'h06); fr_end();
    wait_wc();
    expect_byte(8'h06, "R11 last lock byte");
    expect_byte(8'h06, "R9 status repeats");
    status_frame(2);
    op_only(8'h06);
    wbuf[0] = 8'hEE; write_frame(16'h0001, 1);
    expect_byte(8'h06, "R12 locked write starts no cycle");
    status_frame(1);
    expect_byte(8'hC1, "R12 locked data kept");
    read_frame(16'h0001, 1);
    op_only(8'h06);
    wbuf[0] = 8'h5A; write_frame(16'h0020, 1); wait_wc();
    expect_byte(8'h5A, "R12 unlocked page writable");
    read_frame(16'h0020, 1);

    // R11 partial lock byte leaves code unchanged
    op_only(8'h06);
    fr_start(); xfer(8'h01); xfer(8'h07); xfer_bits(8'h00, 2); fr_end();
    tick(50);
    expect_byte(8'h06, "R11 partial lock ignored");
    status_frame(1);

    // R14 unknown opcode ignores the frame
    fr_start(); xfer(8'hAB); xfer(8'h05);
    chk(!so_oe, "R14 unknown opcode quiet", {15'h0, so_oe}, 16'h0);
    xfer(8'h00);
    chk(!so_oe, "R14 rest of frame ignored", {15'h0, so_oe}, 16'h0);
    fr_end();
    expect_byte(8'h44, "R14 next frame served");
    read_frame(16'h0010, 1);

    // R12 upper quarter
    op_only(8'h06);
    lock_frame(8'h04); wait_wc();
    expect_byte(8'h04, "R11 upper quarter code");
    status_frame(1);
    op_only(8'h06);
    wbuf[0] = 8'h00; write_frame(16'h03F0, 1);
    expect_byte(8'h04, "R12 upper quarter no cycle");
    status_frame(1);
    expect_byte(8'h52, "R12 upper quarter data kept");
    read_frame(16'h03F0, 1);
    op_only(8'h06);
    wbuf[0] = 8'hEF; write_frame(16'h0001, 1); wait_wc();
    expect_byte(8'hEF, "R12 lower page unlocked");
    read_frame(16'h0001, 1);

    chk(exp_v.size() == 0, "scoreboard drained", 16'(exp_v.size()), 16'h0);
    chk(!so_oe, "R2 final oe", {15'h0, so_oe}, 16'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule